// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel that sits on a free-running up-counter. On every running cycle it compares the counter with a shadow copy of a compare value. When they are equal, a reference signal changes in the way the 3-bit mode field selects: it can hold, be set, be cleared or toggle. Two further modes drive the reference to a fixed level and ignore the comparison. The match still sets a sticky flag in those two modes.

A polarity bit and an output enable map the active-high reference onto the pin. Software reaches the block through a small write-only register port. That port carries a control word, the compare value, the wrap value of the counter and a flag-clear strobe. With preload enabled, a new compare value waits in a holding register and moves into the shadow copy when the counter wraps. With preload disabled, the new value goes into the shadow copy at once.

Top module: `oc_channel_top`

## Requirements
- R1: While the run bit is 1, the counter steps up by one per clock. In the cycle after it has equalled the wrap value, it reads 0. While run is 0, it holds its value.
- R2: After a synchronous active-low reset, the outputs are as follows: count is 0, reference is 0, flag is 0, interrupt is 0 and pin is 0. The wrap value resets to all ones. The compare value and the control word reset to 0.
- R3: Mode 000 (frozen) leaves the reference unchanged, including on a match. Modes 110 and 111 behave the same way.
- R4: A match happens in a cycle where run is 1 and the counter equals the shadow compare value. In mode 001 a match drives the reference to 1, and in mode 010 it drives the reference to 0. The new value is visible on the next cycle.
- R5: In mode 011, each match inverts the reference on the next cycle.
- R6: Mode 100 drives the reference to 0 and mode 101 drives it to 1. The level appears on the cycle after the mode is in effect, whatever the comparison result.
- R7: A match sets the flag on the next cycle in every mode, including 100 and 101.
- R8: The comparison always uses the shadow copy. With preload enabled, a compare write reaches the shadow copy only on a counter wrap. With preload disabled, it reaches the shadow copy on the next edge.
- R9: The flag is sticky. A write to select 3 with data bit 0 set clears it. A match in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when the flag is set and the interrupt enable bit is 1.
- R11: The pin follows the reference XOR the polarity bit when the output enable is 1. It sits at the polarity bit when the output enable is 0.
- R12: A write with cfg_we high takes effect at the next edge. The select codes are: 0 for the control word, 1 for the compare value, 2 for the wrap value and 3 for the flag clear. The control word bits are: run on bit 0, mode on bits 3:1, polarity on bit 4, output enable on bit 5, preload enable on bit 6 and interrupt enable on bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Write data |
| count | output | 16 | Current counter value |
| oc_ref | output | 1 | Active-high reference signal |
| oc_pin | output | 1 | Channel output after polarity and enable |
| cmp_flag | output | 1 | Sticky compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
The count, reference and flag are registers. Each one shows the effect of a write or a match on the first clock edge after the cycle in which that write or match occurred. The pin and the interrupt are combinational functions of these registers, so they change in the same cycle as the registers. The bench drives inputs and compares every output at the falling edge, half a cycle away from the edge where the design updates. Its behavioural model advances at the rising edge, from the same inputs the design sees, so each comparison covers exactly one edge of delay. Directed waits on the model's counter place a flag clear in a match cycle, which checks the set-beats-clear rule on the following edge.

// File: rtl/oc_pkg.sv
// Package: shared encodings for the output compare channel.
// Assumes control word layout as documented in the brief (R12).
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN   = 3'b000,
        OCM_SET      = 3'b001,
        OCM_CLEAR    = 3'b010,
        OCM_TOGGLE   = 3'b011,
        OCM_FORCE_LO = 3'b100,
        OCM_FORCE_HI = 3'b101,
        OCM_RSVD6    = 3'b110,
        OCM_RSVD7    = 3'b111
    } oc_mode_e;

    typedef struct packed {
        logic     irq_en;
        logic     preload_en;
        logic     out_en;
        logic     pol;
        oc_mode_e mode;
        logic     run;
    } oc_ctrl_t;

    localparam int CTRL_W = $bits(oc_ctrl_t);

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_CMP    = 2'd1;
    localparam logic [1:0] SEL_RELOAD = 2'd2;
    localparam logic [1:0] SEL_CLR    = 2'd3;

endpackage

// File: rtl/oc_counter.sv
// Module: up-counter that wraps to zero after reaching a programmable value.
// Assumes reload is stable for the cycle it is sampled; counts only when run=1.
module oc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    // Wrap strobe: counter sits at the wrap value while running.
    assign wrap = run && (cnt == reload);

    // Counter register: step up, or return to zero after the wrap value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= wrap ? '0 : cnt + ONE;
    end

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == reload) |=> (cnt == '0));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == $past(cnt)));

endmodule

// File: rtl/oc_compare.sv
// Module: preload and shadow compare registers plus the equality detector.
// Assumes a direct write outranks a wrap transfer when preload is disabled.
module oc_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    input  logic         preload_en,
    input  logic         wrap,
    input  logic         run,
    input  logic [W-1:0] cnt,
    output logic         match
);
    logic [W-1:0] hold_q;
    logic [W-1:0] shadow_q;

    // Equality against the shadow copy only, while counting.
    assign match = run && (cnt == shadow_q);

    // Holding register: captures every compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_cmp)
            hold_q <= wdata;
    end

    // Shadow register: direct load without preload, wrap transfer with it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_cmp && !preload_en)
            shadow_q <= wdata;
        else if (preload_en && wrap)
            shadow_q <= hold_q;
    end

    // R8
    shadow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !wrap) |=> (shadow_q == $past(shadow_q)));

endmodule

// File: rtl/oc_ref_gen.sv
// Module: reference signal state machine driven by the mode field.
// Assumes match is a single-cycle qualifier; reserved modes hold the level.
module oc_ref_gen
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  oc_mode_e mode,
    input  logic     match,
    output logic     ref_q
);
    // Reference update: mode decides the effect of a match or a forced level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= 1'b0;
        else begin
            case (mode)
                OCM_SET:      if (match) ref_q <= 1'b1;
                OCM_CLEAR:    if (match) ref_q <= 1'b0;
                OCM_TOGGLE:   if (match) ref_q <= ~ref_q;
                OCM_FORCE_LO: ref_q <= 1'b0;
                OCM_FORCE_HI: ref_q <= 1'b1;
                default:      ref_q <= ref_q;
            endcase
        end
    end

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OCM_FROZEN) |=> (ref_q == $past(ref_q)));

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OCM_TOGGLE && match) |=> (ref_q != $past(ref_q)));

    // R6
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OCM_FORCE_HI) |=> ref_q);

    // R6
    force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OCM_FORCE_LO) |=> !ref_q);

endmodule

// File: rtl/oc_channel_top.sv
// Module: output compare channel top; config registers, flag and pin mapping.
// Assumes a simple write strobe port with no read path; all writes land at the next edge.
module oc_channel_top
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    output logic [W-1:0] count,
    output logic         oc_ref,
    output logic         oc_pin,
    output logic         cmp_flag,
    output logic         irq
);
    oc_ctrl_t     ctrl_q;
    logic [W-1:0] reload_q;
    logic         wrap;
    logic         match;
    logic         flag_q;
    logic         clr_hit;
    logic         wr_cmp;

    assign wr_cmp  = cfg_we && (cfg_sel == SEL_CMP);
    assign clr_hit = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (cfg_we && cfg_sel == SEL_CTRL)
            ctrl_q <= oc_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end

    // Counter wrap value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '1;
        else if (cfg_we && cfg_sel == SEL_RELOAD)
            reload_q <= cfg_wdata;
    end

    oc_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.run),
        .reload (reload_q),
        .cnt    (count),
        .wrap   (wrap)
    );

    oc_compare #(.W(W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmp     (wr_cmp),
        .wdata      (cfg_wdata),
        .preload_en (ctrl_q.preload_en),
        .wrap       (wrap),
        .run        (ctrl_q.run),
        .cnt        (count),
        .match      (match)
    );

    oc_ref_gen u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (ctrl_q.mode),
        .match (match),
        .ref_q (oc_ref)
    );

    // Sticky match flag: a match outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (clr_hit)
            flag_q <= 1'b0;
    end

    assign cmp_flag = flag_q;
    assign irq      = flag_q & ctrl_q.irq_en;
    assign oc_pin   = ctrl_q.out_en ? (oc_ref ^ ctrl_q.pol) : ctrl_q.pol;

    // R7
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_hit) |=> cmp_flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !match) |=> !cmp_flag);

endmodule

// File: tb/oc_channel_top_test.sv
`timescale 1ns/1ps
module oc_channel_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] count;
    logic        oc_ref, oc_pin, cmp_flag, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    int m_cnt = 0, m_reload = 65535, m_hold = 0, m_shadow = 0;
    int m_mode = 0;
    bit m_run = 0, m_pol = 0, m_oe = 0, m_pe = 0, m_ie = 0;
    bit m_ref = 0, m_flag = 0, m_pending = 0;

    always #2.5 clk = ~clk;

    oc_channel_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .count(count), .oc_ref(oc_ref),
        .oc_pin(oc_pin), .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Behavioural model advanced at each rising edge.
    always @(posedge clk) begin : model
        bit mt, wr;
        int nc, ns, nh;
        bit nr, nf, np;
        if (!rst_n) begin
            m_cnt = 0; m_reload = 65535; m_hold = 0; m_shadow = 0; m_mode = 0;
            m_run = 0; m_pol = 0; m_oe = 0; m_pe = 0; m_ie = 0;
            m_ref = 0; m_flag = 0; m_pending = 0;
        end else begin
            mt = m_run && (m_cnt == m_shadow);
            wr = m_run && (m_cnt == m_reload);
            nc = m_run ? (wr ? 0 : (m_cnt + 1) % 65536) : m_cnt;
            nr = m_ref;
            case (m_mode)
                1: if (mt) nr = 1;
                2: if (mt) nr = 0;
                3: if (mt) nr = !m_ref;
                4: nr = 0;
                5: nr = 1;
                default: ;
            endcase
            nf = m_flag;
            if (cfg_we && cfg_sel == 3 && cfg_wdata[0]) nf = 0;
            if (mt) nf = 1;
            ns = m_shadow; nh = m_hold; np = m_pending;
            if (m_pe && wr) begin ns = m_hold; np = 0; end
            if (cfg_we && cfg_sel == 1) begin
                nh = cfg_wdata;
                if (!m_pe) ns = cfg_wdata; else np = 1;
            end
            if (cfg_we && cfg_sel == 2) m_reload = cfg_wdata;
            if (cfg_we && cfg_sel == 0) begin
                m_run = cfg_wdata[0]; m_mode = cfg_wdata[3:1]; m_pol = cfg_wdata[4];
                m_oe = cfg_wdata[5]; m_pe = cfg_wdata[6]; m_ie = cfg_wdata[7];
            end
            m_cnt = nc; m_ref = nr; m_flag = nf; m_shadow = ns; m_hold = nh; m_pending = np;
        end
    end

    // Compare every output at the falling edge.
    always @(negedge clk) begin : cmp
        string rtag;
        if (!done) begin
            if (!rst_n) begin
                check("R2 count", count, 0);
                check("R2 ref", oc_ref, 0);
                check("R2 flag", cmp_flag, 0);
                check("R2 pin", oc_pin, 0);
                check("R2 irq", irq, 0);
            end else begin
                case (m_mode)
                    1, 2: rtag = "R4 ref";
                    3: rtag = "R5 ref";
                    4, 5: rtag = "R6 ref";
                    default: rtag = "R3 ref";
                endcase
                check("R1 count", count, m_cnt);
                check(rtag, oc_ref, m_ref);
                check(m_pending ? "R8 flag" : "R7 flag", cmp_flag, m_flag);
                check("R10 irq", irq, m_flag & m_ie);
                check("R11/R12 pin", oc_pin, m_oe ? (m_ref ^ m_pol) : m_pol);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : stim
        idle(3);
        rst_n = 1'b1;
        wr(2, 16'd9);
        wr(1, 16'd4);
        wr(0, 16'h00A3);            // set on match
        idle(25);
        wr(3, 16'd1);
        wr(0, 16'h00A5);            // clear on match
        idle(25);
        wr(0, 16'h00A7);            // toggle
        idle(35);
        wr(0, 16'h00B1);            // frozen, pol 1
        idle(25);
        wr(0, 16'h00A9);            // force low
        idle(12);
        wr(3, 16'd1);
        idle(12);                   // R7: flag re-sets while forced
        wr(0, 16'h00BB);            // force high, pol 1
        idle(15);
        wr(0, 16'h009B);            // output disabled
        idle(5);
        wr(0, 16'h00E3);            // preload on, set mode
        wr(3, 16'd1);
        wr(1, 16'd7);               // R8: waits for a wrap
        idle(30);
        wr(0, 16'h00E7);            // toggle with preload
        idle(5);
        // R9: clear lands in a match cycle; match wins
        while (m_cnt != m_shadow) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 set beats clear", cmp_flag, 1);
        idle(5);
        wr(3, 16'd1);
        wr(0, 16'h0067);            // interrupt disabled
        idle(20);
        wr(0, 16'h0066);            // counter stopped
        idle(10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule